// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the system clock into CAN time quanta and arranges them into bit times. Each bit begins with one synchronisation quantum, then a first phase segment and a second phase segment. The block reports the end of every quantum, a strobe at the sample point with the sampled bus level, and a strobe at the start of each bit where a transmitter would put out its next bit. Frame decoding and transmission are left to the blocks that use these strobes.

All timing settings come in as small codes. The prescaler code c gives a quantum of 2(c+1) clocks. The other fields are each stored as the value minus one. Settings are captured only while the configuration hold input is high. While hold is high the block stays idle, and it starts a new bit when hold drops.

The block stays locked to the bus by watching for falling edges (recessive 1 to dominant 0). With hard sync enabled, an edge restarts the bit. Otherwise an edge lengthens or shortens the current bit by at most the jump width. Triple sampling replaces the single sample with a majority of three.

Top module: `can_bit_timing`

## Requirements
- R1: `tq_tick` is a one-clock pulse that repeats every 2(c+1) clocks, where c is the captured 6-bit prescaler code (0 gives 2, 63 gives 128).
- R2: Without bus edges a bit lasts 1 + (s1+1) + (s2+1) quanta, where s1 and s2 are the captured 4-bit and 3-bit segment codes. `sample_stb` and `tx_stb` each pulse once per bit, one clock after the `tq_tick` that ends the quantum they mark.
- R3: `tx_stb` marks the tick that ends the second segment, so the next quantum is the sync quantum. `sample_stb` marks the tick that ends the last quantum of the first segment, 1+(s1+1) ticks after `tx_stb`.
- R4: With `triple_en` low, `rx_bit` takes `rx_in` as sampled at the sample tick. With it high, `rx_bit` takes the majority of `rx_in` at the sample tick and at the two ticks before it. `rx_bit` changes only together with `sample_stb`.
- R5: A falling edge seen at the tick that ends quantum k (counted from 1) of the first segment lengthens that segment by min(k, j) quanta, where j = jump-width code + 1.
- R6: A falling edge seen at the tick that ends quantum k of the second segment (length T2) shortens that segment by min(T2-k, j) quanta. The bit ends at once if the shortened length is k or less.
- R7: A falling edge seen at the tick that ends the sync quantum changes no segment length.
- R8: With `hsync_en` high, a falling edge at any tick ends the current quantum as a sync quantum. No strobe is issued for that tick, the next sample follows s1+1 ticks later, and the next `tx_stb` comes s2+1 ticks after that.
- R9: While `cfg_hold` is high, no tick or strobe is issued and the codes are captured. Code changes while `cfg_hold` is low have no effect on timing.
- R10: During reset `tq_tick`, `sample_stb` and `tx_stb` are low and `rx_bit` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hold | input | 1 | Hold the block idle and capture the timing codes |
| presc_code | input | 6 | Prescaler code c, quantum = 2(c+1) clocks |
| sjw_code | input | 2 | Jump width minus one |
| seg1_code | input | 4 | First phase segment length minus one |
| seg2_code | input | 3 | Second phase segment length minus one |
| triple_en | input | 1 | Majority-of-three sampling |
| hsync_en | input | 1 | Bus idle: falling edges cause a hard sync |
| rx_in | input | 1 | Receive line, 1 = recessive |
| tq_tick | output | 1 | Pulse at the end of every quantum |
| sample_stb | output | 1 | Sample point strobe |
| rx_bit | output | 1 | Sampled bit value, valid with `sample_stb` |
| tx_stb | output | 1 | Start-of-bit strobe for the transmitter |

## Verification
A wrong phase or segment counter does not stay hidden. Within one bit time it moves `sample_stb` or `tx_stb` to the wrong tick, so the bench measures strobe positions in tick indices relative to `tx_stb` or `sample_stb` rather than just counting pulses. A bad resync limit shows up in the single bit that contains the edge. The bench places edges at every quantum of each segment under every jump width to expose it. A fault in the sample history appears only in triple mode, at the next sample point, and only for patterns where the majority differs from the last sample.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } phase_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/cbt_cfg_latch.sv
module cbt_cfg_latch #(
  parameter int PRESC_W = 6,
  parameter int SJW_W   = 2,
  parameter int SEG1_W  = 4,
  parameter int SEG2_W  = 3,
  parameter int CW      = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic [PRESC_W-1:0] presc_code,
  input  logic [SJW_W-1:0]   sjw_code,
  input  logic [SEG1_W-1:0]  seg1_code,
  input  logic [SEG2_W-1:0]  seg2_code,
  input  logic               triple_in,
  output logic [PRESC_W:0]   div_m1,
  output logic [CW-1:0]      t1_len,
  output logic [CW-1:0]      t2_len,
  output logic [CW-1:0]      jump_len,
  output logic               triple_q
);

  // Decoded lengths are kept in registers so the timing path sees no adders.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_m1   <= {{PRESC_W{1'b0}}, 1'b1};
      t1_len   <= CW'(1);
      t2_len   <= CW'(1);
      jump_len <= CW'(1);
      triple_q <= 1'b0;
    end else if (hold) begin
      div_m1   <= {presc_code, 1'b1};
      t1_len   <= CW'(seg1_code) + CW'(1);
      t2_len   <= CW'(seg2_code) + CW'(1);
      jump_len <= CW'(sjw_code) + CW'(1);
      triple_q <= triple_in;
    end
  end

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tq_tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q   <= '0;
      tq_tick <= 1'b0;
    end else if (cnt_q == div_m1) begin
      cnt_q   <= '0;
      tq_tick <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      tq_tick <= 1'b0;
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tq_tick |=> !tq_tick); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    hold |=> !tq_tick); // R9

endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
  import cbt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic tick,
  input  logic rx_in,
  input  logic triple,
  input  logic sample_now,
  output logic edge_fall,
  output logic rx_bit
);

  logic hist1_q, hist2_q;

  // Bus level at the two previous quantum boundaries; the first one also
  // serves as the reference for falling-edge detection.
  assign edge_fall = tick & hist1_q & ~rx_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1_q <= 1'b1;
      hist2_q <= 1'b1;
      rx_bit  <= 1'b1;
    end else if (hold) begin
      hist1_q <= 1'b1;
      hist2_q <= 1'b1;
    end else if (tick) begin
      hist2_q <= hist1_q;
      hist1_q <= rx_in;
      if (sample_now) begin
        rx_bit <= triple ? maj3(rx_in, hist1_q, hist2_q) : rx_in;
      end
    end
  end

endmodule

// File: rtl/cbt_sequencer.sv
module cbt_sequencer
  import cbt_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          tick,
  input  logic          edge_fall,
  input  logic          hsync_en,
  input  logic [CW-1:0] t1_len,
  input  logic [CW-1:0] t2_len,
  input  logic [CW-1:0] jump_len,
  output logic          sample_now,
  output logic          sample_stb,
  output logic          tx_stb
);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim1_q, lim1_d;
  logic [CW-1:0] lim2_q, lim2_d;
  logic [CW-1:0] grow, rest2, shrink, lim1_eff, lim2_eff;
  logic          tx_now;

  always_comb begin
    grow     = (cnt_q < jump_len) ? cnt_q : jump_len;
    rest2    = lim2_q - cnt_q;
    shrink   = (rest2 < jump_len) ? rest2 : jump_len;
    lim1_eff = edge_fall ? (lim1_q + grow) : lim1_q;
    lim2_eff = edge_fall ? (lim2_q - shrink) : lim2_q;

    ph_d       = ph_q;
    cnt_d      = cnt_q;
    lim1_d     = lim1_q;
    lim2_d     = lim2_q;
    sample_now = 1'b0;
    tx_now     = 1'b0;

    if (tick) begin
      if (edge_fall && hsync_en) begin
        ph_d   = PH_SEG1;
        cnt_d  = CW'(1);
        lim1_d = t1_len;
        lim2_d = t2_len;
      end else begin
        case (ph_q)
          PH_SYNC: begin
            ph_d   = PH_SEG1;
            cnt_d  = CW'(1);
            lim1_d = t1_len;
            lim2_d = t2_len;
          end
          PH_SEG1: begin
            lim1_d = lim1_eff;
            if (cnt_q >= lim1_eff) begin
              ph_d       = PH_SEG2;
              cnt_d      = CW'(1);
              sample_now = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_SEG2: begin
            lim2_d = lim2_eff;
            if (cnt_q >= lim2_eff) begin
              ph_d   = PH_SYNC;
              cnt_d  = '0;
              tx_now = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: begin
            ph_d  = PH_SYNC;
            cnt_d = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      ph_q       <= PH_SYNC;
      cnt_q      <= '0;
      lim1_q     <= t1_len;
      lim2_q     <= t2_len;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      cnt_q      <= cnt_d;
      lim1_q     <= lim1_d;
      lim2_q     <= lim2_d;
      sample_stb <= sample_now;
      tx_stb     <= tx_now;
    end
  end

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    (sample_stb || tx_stb) |-> $past(tick)); // R2

  AST_SEG1_BOUND: assert property (@(posedge clk) disable iff (rst || hold)
    (ph_q != PH_SYNC) |-> (lim1_q <= t1_len + jump_len)); // R5

  AST_SEG2_FLOOR: assert property (@(posedge clk) disable iff (rst || hold)
    (ph_q == PH_SEG2) |-> (cnt_q >= CW'(1) && cnt_q <= lim2_q)); // R6

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!sample_stb && !tx_stb)); // R9

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
  parameter int PRESC_W = 6,
  parameter int SJW_W   = 2,
  parameter int SEG1_W  = 4,
  parameter int SEG2_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_hold,
  input  logic [PRESC_W-1:0] presc_code,
  input  logic [SJW_W-1:0]   sjw_code,
  input  logic [SEG1_W-1:0]  seg1_code,
  input  logic [SEG2_W-1:0]  seg2_code,
  input  logic               triple_en,
  input  logic               hsync_en,
  input  logic               rx_in,
  output logic               tq_tick,
  output logic               sample_stb,
  output logic               rx_bit,
  output logic               tx_stb
);

  localparam int DIV_W = PRESC_W + 1;
  localparam int MX_A  = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;
  localparam int MX_B  = (MX_A > SJW_W) ? MX_A : SJW_W;
  localparam int CW    = MX_B + 2;

  logic [DIV_W-1:0] div_m1;
  logic [CW-1:0]    t1_len, t2_len, jump_len;
  logic             triple_q, sample_now, edge_fall;

  cbt_cfg_latch #(
    .PRESC_W(PRESC_W), .SJW_W(SJW_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .CW(CW)
  ) cfg_i (
    .clk(clk), .rst(rst), .hold(cfg_hold),
    .presc_code(presc_code), .sjw_code(sjw_code),
    .seg1_code(seg1_code), .seg2_code(seg2_code), .triple_in(triple_en),
    .div_m1(div_m1), .t1_len(t1_len), .t2_len(t2_len),
    .jump_len(jump_len), .triple_q(triple_q)
  );

  cbt_prescaler #(.DIV_W(DIV_W)) presc_i (
    .clk(clk), .rst(rst), .hold(cfg_hold), .div_m1(div_m1), .tq_tick(tq_tick)
  );

  cbt_sampler samp_i (
    .clk(clk), .rst(rst), .hold(cfg_hold), .tick(tq_tick), .rx_in(rx_in),
    .triple(triple_q), .sample_now(sample_now),
    .edge_fall(edge_fall), .rx_bit(rx_bit)
  );

  cbt_sequencer #(.CW(CW)) seq_i (
    .clk(clk), .rst(rst), .hold(cfg_hold), .tick(tq_tick),
    .edge_fall(edge_fall), .hsync_en(hsync_en),
    .t1_len(t1_len), .t2_len(t2_len), .jump_len(jump_len),
    .sample_now(sample_now), .sample_stb(sample_stb), .tx_stb(tx_stb)
  );

  AST_BIT_ONLY_AT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |-> $stable(rx_bit)); // R4

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && tx_stb)); // R3

endmodule

// File: tb/can_bit_timing_tb_top.sv
module can_bit_timing_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_hold = 1'b0;
  logic [5:0] presc_code = '0;
  logic [1:0] sjw_code = '0;
  logic [3:0] seg1_code = '0;
  logic [2:0] seg2_code = '0;
  logic       triple_en = 1'b0;
  logic       hsync_en = 1'b0;
  logic       rx_in = 1'b1;
  logic       tq_tick, sample_stb, rx_bit, tx_stb;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int tick_idx = 0;
  int wd = 0;

  always #4 clk = ~clk;

  can_bit_timing dut_i (
    .clk(clk), .rst(rst), .cfg_hold(cfg_hold),
    .presc_code(presc_code), .sjw_code(sjw_code),
    .seg1_code(seg1_code), .seg2_code(seg2_code),
    .triple_en(triple_en), .hsync_en(hsync_en), .rx_in(rx_in),
    .tq_tick(tq_tick), .sample_stb(sample_stb), .rx_bit(rx_bit), .tx_stb(tx_stb)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc = cyc + 1;
    if (tq_tick) tick_idx = tick_idx + 1;
  endtask

  task automatic wait_tick();
    do step(); while (!tq_tick);
  endtask

  task automatic wait_sample();
    do step(); while (!sample_stb);
  endtask

  task automatic wait_tx();
    do step(); while (!tx_stb);
  endtask

  // Make rx_in take value v at tick number n (and not earlier).
  task automatic drive_at(input int n, input logic v);
    while (tick_idx < n - 1) step();
    if (tq_tick) step();
    rx_in = v;
  endtask

  task automatic load(input int c, input int sj, input int s1, input int s2,
                      input bit tr, input logic rx_v);
    step();
    cfg_hold   = 1'b1;
    presc_code = 6'(c);
    sjw_code   = 2'(sj);
    seg1_code  = 4'(s1);
    seg2_code  = 3'(s2);
    triple_en  = tr;
    rx_in      = rx_v;
    repeat (3) step();
    cfg_hold = 1'b0;
  endtask

  initial begin
    int x, s, e, c0, c1, c2, quiet_bad;

    // R10: reset values
    repeat (3) step();
    chk(tq_tick == 1'b0 && sample_stb == 1'b0 && tx_stb == 1'b0, "R10 strobes low in reset",
        {tq_tick, sample_stb, tx_stb}, 0);
    chk(rx_bit == 1'b1, "R10 rx_bit recessive in reset", rx_bit, 1);
    rst = 1'b0;

    // R9: nothing happens while held
    cfg_hold = 1'b1;
    quiet_bad = 0;
    for (int i = 0; i < 12; i++) begin
      step();
      if (tq_tick || sample_stb || tx_stb) quiet_bad = quiet_bad + 1;
    end
    chk(quiet_bad == 0, "R9 quiet while held", quiet_bad, 0);
    cfg_hold = 1'b0;

    // R1: prescaler sweep over every code
    for (int c = 0; c < 64; c++) begin
      load(c, 0, 0, 0, 1'b0, 1'b1);
      wait_tick(); c0 = cyc;
      wait_tick(); c1 = cyc;
      wait_tick(); c2 = cyc;
      chk(c1 - c0 == 2 * (c + 1), "R1 tick period", c1 - c0, 2 * (c + 1));
      chk(c2 - c1 == 2 * (c + 1), "R1 tick period repeat", c2 - c1, 2 * (c + 1));
    end

    // R2 / R3: every segment combination, quantum of 2 clocks
    for (int s1 = 0; s1 < 16; s1++) begin
      for (int s2 = 0; s2 < 8; s2++) begin
        load(0, 0, s1, s2, 1'b0, 1'b1);
        wait_sample();
        wait_tx(); x = tick_idx;
        wait_sample(); s = tick_idx; c1 = cyc;
        wait_sample(); c2 = cyc;
        chk(s - x == 2 + s1, "R3 tx to sample ticks", s - x, 2 + s1);
        chk(c2 - c1 == 2 * (3 + s1 + s2), "R2 bit period clocks", c2 - c1, 2 * (3 + s1 + s2));
      end
    end

    // R9: code changes while running are ignored
    load(0, 0, 3, 2, 1'b0, 1'b1);
    wait_sample();
    presc_code = 6'd5; seg1_code = 4'd10; seg2_code = 3'd7;
    wait_sample(); c1 = cyc;
    wait_sample(); c2 = cyc;
    chk(c2 - c1 == 16, "R9 running codes ignored", c2 - c1, 16);

    // R5 / R7: edge in sync quantum (k = 0) and in first segment (k >= 1)
    for (int sj = 0; sj < 4; sj++) begin
      for (int k = 0; k <= 8; k++) begin
        load(0, sj, 7, 2, 1'b0, 1'b1);
        wait_tx(); x = tick_idx;
        drive_at(x + 1 + k, 1'b0);
        wait_sample();
        if (k == 0)
          chk(tick_idx == x + 9, "R7 sync edge no change", tick_idx - x, 9);
        else
          chk(tick_idx == x + 9 + imin(k, sj + 1), "R5 seg1 lengthen",
              tick_idx - x, 9 + imin(k, sj + 1));
      end
    end

    // R6: edge in second segment
    for (int sj = 0; sj < 4; sj++) begin
      for (int k = 1; k <= 8; k++) begin
        load(0, sj, 3, 7, 1'b0, 1'b1);
        wait_sample(); s = tick_idx;
        drive_at(s + k, 1'b0);
        wait_tx();
        chk(tick_idx == s + 8 - imin(8 - k, sj + 1), "R6 seg2 shorten",
            tick_idx - s, 8 - imin(8 - k, sj + 1));
      end
    end

    // R8: hard sync at several positions in the bit
    hsync_en = 1'b1;
    for (int j = 0; j < 9; j++) begin
      load(0, 1, 5, 2, 1'b0, 1'b1);
      e = tick_idx + 3 + j;
      drive_at(e, 1'b0);
      wait_sample();
      chk(tick_idx == e + 6, "R8 hard sync sample", tick_idx - e, 6);
      wait_tx();
      chk(tick_idx == e + 9, "R8 hard sync tx", tick_idx - e, 9);
    end
    hsync_en = 1'b0;

    // R4: single versus majority sampling, rising patterns only
    for (int tr = 0; tr < 2; tr++) begin
      for (int p = 0; p < 4; p++) begin
        logic [2:0] pat;
        logic       expb;
        pat = (p == 0) ? 3'b000 : (p == 1) ? 3'b001 : (p == 2) ? 3'b011 : 3'b111;
        expb = (tr == 1) ? ((pat[2] & pat[1]) | (pat[2] & pat[0]) | (pat[1] & pat[0])) : pat[0];
        load(0, 0, 3, 1, tr[0], 1'b0);
        wait_tx();
        wait_tx(); x = tick_idx;
        drive_at(x + 3, pat[2]);
        drive_at(x + 4, pat[1]);
        drive_at(x + 5, pat[0]);
        wait_sample();
        chk(tick_idx == x + 5, "R3 sample tick in R4 run", tick_idx - x, 5);
        chk(rx_bit == expb, "R4 sampled value", rx_bit, expb);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule